// File: doc/BRIEF.md
# Dual-Modulus PLL Divider Programming Sequencer

This block programs an integer-N frequency synthesizer that counts its feedback path with a dual-modulus prescaler. The caller supplies the wanted total feedback divide ratio, a two-bit prescaler code, the reference divider value and a handful of control fields, then pulses `start`. The block splits the ratio into the swallow count A and the main count B. It checks that the split is legal and assembles four 24-bit latch words, each tagged in its two low bits with a latch address. It shifts the words out over a three-wire serial link in the power-up order the synthesizer needs.

An illegal split raises `err` and sends nothing. A legal split raises `busy` until the last word has been latched. Frequency planning, the reference clock and the oscillator itself sit outside this block.

Top module: `pll_prog_seq`

## Requirements
- R1: The prescaler code `psc_sel` selects the modulus M: 8 for code 0, 16 for code 1, 32 for code 2 and 64 for code 3. B is the floor of `n_div`/M and A is `n_div` minus M*B.
- R2: When a start is taken and B < A, no word is sent. In the cycle after that start `err` is 1 and `busy` is 0. `err` stays 1 until a later start is accepted, and an accepted start clears it.
- R3: A split whose B exceeds 8191 (13-bit field) or whose A exceeds 31 (5-bit field) is refused exactly as in R2.
- R4: An accepted request sends four words in this order: the reference word (address 0), the function word (address 2), the initialization word (address 3) and the divider word (address 1).
- R5: The reference word holds `r_div` in bits 15:2, `ldp` in bit 20 and address 0 in bits 1:0. All other bits are zero.
- R6: The divider word holds A in bits 6:2, B in bits 20:8, `cp_gain` in bit 21 and address 1 in bits 1:0. All other bits are zero.
- R7: The function and initialization words are identical except for their addresses, 2 and 3. They carry `psc_sel` in bits 23:22 and `muxout` in bits 6:4. Bits 21:7 and 3:2 come from `misc_ctrl`. The values of `misc_ctrl` bits 23:22, 6:4 and 1:0 have no effect.
- R8: Each word is sent as 24 bits, most significant first, so three bytes go out high byte first. `sdata` is stable while `sclk` is high, and `sclk` rests low between bits and between words.
- R9: `le` is low while a word shifts. After the last bit it is high for one serial clock period (2*HALF clock cycles), and `sclk` stays low during that time.
- R10: `busy` rises in the cycle after an accepted start and falls after the fourth latch pulse. A start while `busy` is high is ignored.
- R11: After reset `busy`, `err`, `le` and `sclk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| n_div | input | N_W (19) | Total feedback divide ratio |
| psc_sel | input | 2 | Prescaler modulus code |
| r_div | input | R_W (14) | Reference divider value |
| ldp | input | 1 | Lock-detect precision bit |
| cp_gain | input | 1 | Charge-pump gain bit |
| muxout | input | 3 | Test-output select field |
| misc_ctrl | input | 24 | Remaining function/initialization bits |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| le | output | 1 | Latch enable |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last request refused |

## Verification
The properties assume that the request inputs are valid whenever `start` is high, and that `start` is a single-cycle pulse sampled on the clock. The bench drives each request at a falling clock edge and holds its values until the sequence ends. The one exception is the deliberate mid-transfer start, which uses changed values to show that they are not taken. The refusal properties rely on the splitter's verdict for the inputs present in the start cycle. The stimulus therefore covers both sides of each boundary: B equal to A, B just below A, and A or B one step outside its field.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int WORD_W = 24;
  localparam int A_W    = 5;
  localparam int B_W    = 13;

  typedef enum logic [1:0] {
    ADDR_REF  = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_FUNC = 2'd2,
    ADDR_INIT = 2'd3
  } latch_addr_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LATCH = 2'd2
  } sh_state_e;

  // bits of the control word taken from the free-form input
  localparam logic [WORD_W-1:0] CTRL_KEEP = 24'h3FFF8C;

  function automatic logic [6:0] psc_modulus(input logic [1:0] code);
    return 7'd8 << code;
  endfunction

  function automatic logic [WORD_W-1:0] tag_word(input logic [WORD_W-1:0] body,
                                                 input latch_addr_e addr);
    return {body[WORD_W-1:2], addr};
  endfunction
endpackage

// File: rtl/pll_div_split.sv
module pll_div_split
  import pll_seq_pkg::*;
#(
  parameter int N_W = 19
) (
  input  logic [N_W-1:0] n_div,
  input  logic [1:0]     psc_sel,
  output logic [A_W-1:0] a_fld,
  output logic [B_W-1:0] b_fld,
  output logic           bad
);
  localparam logic [N_W-1:0] B_MAX = N_W'((1 << B_W) - 1);
  localparam logic [N_W-1:0] A_MAX = N_W'((1 << A_W) - 1);

  logic [N_W-1:0] mask;
  logic [N_W-1:0] b_full;
  logic [N_W-1:0] a_full;

  always_comb begin
    mask   = N_W'(psc_modulus(psc_sel)) - 1'b1;
    b_full = n_div >> (32'd3 + 32'(psc_sel));
    a_full = n_div & mask;
    bad    = (b_full < a_full) || (b_full > B_MAX) || (a_full > A_MAX);
    a_fld  = a_full[A_W-1:0];
    b_fld  = b_full[B_W-1:0];
  end
endmodule

// File: rtl/pll_word_build.sv
module pll_word_build
  import pll_seq_pkg::*;
#(
  parameter int R_W = 14
) (
  input  logic [R_W-1:0]    r_div,
  input  logic              ldp,
  input  logic              cp_gain,
  input  logic [1:0]        psc_sel,
  input  logic [2:0]        muxout,
  input  logic [WORD_W-1:0] misc_ctrl,
  input  logic [A_W-1:0]    a_fld,
  input  logic [B_W-1:0]    b_fld,
  output logic [WORD_W-1:0] w_ref,
  output logic [WORD_W-1:0] w_func,
  output logic [WORD_W-1:0] w_init,
  output logic [WORD_W-1:0] w_div
);
  logic [WORD_W-1:0] ctrl;

  always_comb begin
    w_ref  = tag_word((WORD_W'(r_div) << 2) | (WORD_W'(ldp) << 20), ADDR_REF);
    ctrl   = (misc_ctrl & CTRL_KEEP) | (WORD_W'(psc_sel) << 22) | (WORD_W'(muxout) << 4);
    w_func = tag_word(ctrl, ADDR_FUNC);
    w_init = tag_word(ctrl, ADDR_INIT);
    w_div  = tag_word((WORD_W'(cp_gain) << 21) | (WORD_W'(b_fld) << 8) | (WORD_W'(a_fld) << 2),
                      ADDR_DIV);
  end
endmodule

// File: rtl/pll_spi_shift.sv
module pll_spi_shift
  import pll_seq_pkg::*;
#(
  parameter int W    = 24,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         sclk,
  output logic         sdata,
  output logic         le,
  output logic         idle,
  output logic         done
);
  localparam int PH_W = $clog2(2 * HALF) + 1;
  localparam int BC_W = $clog2(W) + 1;
  localparam logic [PH_W-1:0] PH_HALF_END = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_LE_END   = PH_W'(2 * HALF - 1);
  localparam logic [BC_W-1:0] BC_LAST     = BC_W'(W - 1);

  sh_state_e       state;
  logic [W-1:0]    sh;
  logic [PH_W-1:0] ph;
  logic [BC_W-1:0] bc;

  assign idle = (state == SH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      sh    <= '0;
      ph    <= '0;
      bc    <= '0;
      sclk  <= 1'b0;
      sdata <= 1'b0;
      le    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SH_IDLE: begin
          if (load) begin
            sh    <= word;
            sdata <= word[W-1];
            bc    <= '0;
            ph    <= '0;
            sclk  <= 1'b0;
            state <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (ph == PH_HALF_END) begin
            ph <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bc == BC_LAST) begin
                state <= SH_LATCH;
                le    <= 1'b1;
                sdata <= 1'b0;
              end else begin
                bc    <= bc + 1'b1;
                sh    <= sh << 1;
                sdata <= sh[W-2];
              end
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SH_LATCH: begin
          if (ph == PH_LE_END) begin
            ph    <= '0;
            le    <= 1'b0;
            done  <= 1'b1;
            state <= SH_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int N_W  = 19,
  parameter int R_W  = 14,
  parameter int HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_W-1:0]    n_div,
  input  logic [1:0]        psc_sel,
  input  logic [R_W-1:0]    r_div,
  input  logic              ldp,
  input  logic              cp_gain,
  input  logic [2:0]        muxout,
  input  logic [WORD_W-1:0] misc_ctrl,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              busy,
  output logic              err
);
  localparam int NWORDS = 4;

  logic [A_W-1:0]    a_fld;
  logic [B_W-1:0]    b_fld;
  logic              split_bad;
  logic              accept;
  logic              load;
  logic              word_done;
  logic              sh_idle;
  logic              launched;
  logic [1:0]        idx;
  logic [WORD_W-1:0] built [NWORDS];
  logic [WORD_W-1:0] words [NWORDS];

  pll_div_split #(.N_W(N_W)) u_split (
    .n_div(n_div), .psc_sel(psc_sel), .a_fld(a_fld), .b_fld(b_fld), .bad(split_bad)
  );

  // built[] is in transmit order: reference, function, init, divider
  pll_word_build #(.R_W(R_W)) u_build (
    .r_div(r_div), .ldp(ldp), .cp_gain(cp_gain), .psc_sel(psc_sel), .muxout(muxout),
    .misc_ctrl(misc_ctrl), .a_fld(a_fld), .b_fld(b_fld),
    .w_ref(built[0]), .w_func(built[1]), .w_init(built[2]), .w_div(built[3])
  );

  assign accept = start & ~busy;
  assign load   = busy & sh_idle & ~launched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      launched <= 1'b0;
      idx      <= '0;
    end else if (accept) begin
      if (split_bad) begin
        err <= 1'b1;
      end else begin
        err      <= 1'b0;
        busy     <= 1'b1;
        launched <= 1'b0;
        idx      <= '0;
      end
    end else if (busy) begin
      if (load) launched <= 1'b1;
      if (word_done) begin
        launched <= 1'b0;
        if (idx == 2'(NWORDS - 1)) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_wreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else if (accept && !split_bad) words[g] <= built[g];
    end
  end

  pll_spi_shift #(.W(WORD_W), .HALF(HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(words[idx]),
    .sclk(sclk), .sdata(sdata), .le(le), .idle(sh_idle), .done(word_done)
  );
endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic split_bad,
  input logic word_done,
  input logic busy,
  input logic err,
  input logic sclk,
  input logic sdata,
  input logic le
);
  a_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && split_bad |=> err && !busy);

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !split_bad |=> busy && !err);

  a_r9_le_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !sclk);

  a_r9_le_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le) |-> busy);

  a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(word_done));

  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(sdata));
endmodule

bind pll_prog_seq pll_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .split_bad(split_bad),
  .word_done(word_done), .busy(busy), .err(err), .sclk(sclk), .sdata(sdata), .le(le)
);

// File: tb/pll_prog_seq_test.sv
module pll_prog_seq_test;
  localparam int N_W  = 19;
  localparam int R_W  = 14;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_W-1:0] n_div = '0;
  logic [1:0] psc_sel = '0;
  logic [R_W-1:0] r_div = '0;
  logic ldp = 1'b0, cp_gain = 1'b0;
  logic [2:0] muxout = '0;
  logic [23:0] misc_ctrl = '0;
  logic sclk, sdata, le, busy, err;

  int checks = 0, errors = 0;
  int pushed = 0, received = 0;
  longint cyc = 0;
  longint le_t0 = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [23:0] shreg = '0;
  int nbits = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  pll_prog_seq #(.N_W(N_W), .R_W(R_W), .HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_div(n_div), .psc_sel(psc_sel),
    .r_div(r_div), .ldp(ldp), .cp_gain(cp_gain), .muxout(muxout), .misc_ctrl(misc_ctrl),
    .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .err(err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: collect bits on rising sclk, compare on latch pulse
  always @(posedge sclk) begin
    shreg = {shreg[22:0], sdata};
    nbits++;
  end

  always @(posedge le) begin
    le_t0 = cyc;
    chk("R8 bits per word", nbits, 24);
    nbits = 0;
    received++;
    if (exp_q.size() == 0) chk("R10 unexpected word", shreg, 0);
    else begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, shreg, e);
    end
  end

  always @(negedge le) chk("R9 le width", cyc - le_t0, 2 * HALF);

  // expected words per R1, R4..R7
  task automatic push_expected(input int n, input int p, input int r, input bit l,
                               input bit cp, input int mx, input logic [23:0] misc);
    int m, b, a;
    logic [23:0] ctl;
    m = 8 * (1 << p);
    b = n / m;
    a = n - m * b;
    ctl = 24'(p) * 24'h400000 + 24'(mx) * 24'h10 + (misc & 24'h3FFF8C);
    exp_q.push_back(24'(l) * 24'h100000 + 24'(r) * 24'd4);        tag_q.push_back("R5 ref word");
    exp_q.push_back(ctl + 24'd2);                                  tag_q.push_back("R7 func word");
    exp_q.push_back(ctl + 24'd3);                                  tag_q.push_back("R7 init word");
    exp_q.push_back(24'(cp) * 24'h200000 + 24'(b) * 24'h100 + 24'(a) * 24'd4 + 24'd1);
    tag_q.push_back("R6 div word (R1 split, R4 order)");
    pushed += 4;
  endtask

  task automatic request(input int n, input int p, input int r, input bit l, input bit cp,
                         input int mx, input logic [23:0] misc, input bit good, input string rq);
    int m, b, a;
    m = 8 * (1 << p);
    b = n / m;
    a = n - m * b;
    @(negedge clk);
    n_div = N_W'(n); psc_sel = 2'(p); r_div = R_W'(r); ldp = l; cp_gain = cp;
    muxout = 3'(mx); misc_ctrl = misc; start = 1'b1;
    if (good) push_expected(n, p, r, l, cp, mx, misc);
    @(negedge clk);
    start = 1'b0;
    if (good) begin
      chk("R10 busy after start", busy, 1);
      chk("R2 err cleared on accept", err, 0);
      while (busy) @(negedge clk);
      chk("R4 all words sent", exp_q.size(), 0);
    end else begin
      chk({rq, " err raised"}, err, 1);
      chk({rq, " busy stays low"}, busy, 0);
      repeat (150) @(negedge clk);
      chk({rq, " no words sent"}, received, pushed);
      chk({rq, " err held"}, err, 1);
    end
    if (b < a) chk("R2 bench model agrees split refused", good, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 busy reset", busy, 0);
    chk("R11 err reset", err, 0);
    chk("R11 le reset", le, 0);
    chk("R11 sclk reset", sclk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    request(45, 0, 1, 1'b0, 1'b1, 5, 24'h000000, 1'b1, "R1");          // B=A=5
    request(1000, 1, 1234, 1'b1, 1'b0, 3, 24'h0A5A00, 1'b1, "R1");
    request(133, 3, 7, 1'b1, 1'b1, 1, 24'h0, 1'b0, "R2");               // B=2 < A=5
    request(5000, 2, 16383, 1'b1, 1'b1, 7, 24'hFFFFFF, 1'b1, "R7");     // ignored misc bits
    request(524287, 3, 9, 1'b0, 1'b0, 2, 24'h0, 1'b0, "R3");            // A=63 too wide
    request(65536, 0, 9, 1'b0, 1'b0, 2, 24'h0, 1'b0, "R3");             // B=8192 too wide
    request(524255, 3, 8191, 1'b0, 1'b1, 4, 24'h123456, 1'b1, "R3");    // top legal

    // R10: start during a transfer is ignored
    @(negedge clk);
    n_div = N_W'(2000); psc_sel = 2'd1; r_div = R_W'(77); ldp = 1'b1; cp_gain = 1'b0;
    muxout = 3'd6; misc_ctrl = 24'h000100; start = 1'b1;
    push_expected(2000, 1, 77, 1'b1, 1'b0, 6, 24'h000100);
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    n_div = N_W'(300); psc_sel = 2'd0; r_div = R_W'(3); muxout = 3'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy held during ignored start", busy, 1);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R10 ignored start sent nothing", received, pushed);
    chk("R8 sclk idle low", sclk, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule